// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Converter

This block takes a 4-bit parallel word and sends it out on a single serial line, one bit per bit-clock cycle. The lowest bit goes first. It also gives the upstream data source two clocks made from the bit clock: one at a quarter of its rate and one at an eighth. The source uses these to pace its parallel words.

Two units can be chained to make an 8-bit serializer. The upstream unit's serial output feeds the downstream unit's serial input, and both units run in the eight-clock load mode. The downstream unit sends its own four bits first and then passes on the four bits from the upstream unit.

A sync input clears the internal phase counter at once, without waiting for a clock. This lets the user set where each conversion frame starts. Release of sync is retimed to the bit clock, so the divided clocks never produce a short pulse. The serial output register updates on the falling edge of the bit clock, so the serial line is stable around every rising edge.

Top module: `par_serializer`

## Requirements
- R1: A word is sent one bit per clock, lowest bit first. `par_i[0]` goes out in the first bit time after a load edge and `par_i[3]` goes out in the fourth.
- R2: `div_word_o` runs at one quarter of the clock rate and `div_pair_o` at one eighth. Number the rising edges from the first load edge after sync, starting at n = 0. After edge n, `div_word_o` equals bit 1 of (n+1) mod 8 and `div_pair_o` equals bit 2 of it.
- R3: With `mode8_i` low, a load happens every 4 clocks and each frame is 4 bit times long.
- R4: With `mode8_i` high, a load happens every 8 clocks. Bit times 0 to 3 of each frame carry the local word and bit times 4 to 7 carry data that came in on `ser_i`.
- R5: `ser_i` enters behind bit 3. The value on `ser_i` at rising edge j+1 after a load edge (j = 0..3) appears on `ser_o` in bit time 4+j. Two units in `mode8_i` high, with the upstream `ser_o` wired to the downstream `ser_i` and a common sync, give the downstream word followed by the upstream word.
- R6: `ser_o` changes only on a falling clock edge. Between a rising edge and the next falling edge it still shows the previous bit.
- R7: While `sync_i` is high, both divided clocks are forced low. This takes effect as soon as `sync_i` rises, with no clock edge needed.
- R8: After `sync_i` falls, the first load edge is the third rising edge. The divided clocks stay low until then.
- R9: `par_i` is sampled only at a load edge. Changing it at any other time has no effect on `ser_o`.
- R10: Holding `rst_n` low across a rising edge clears `div_word_o` and `div_pair_o`. It also clears `ser_o` at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Asynchronous frame restart, active high |
| mode8_i | input | 1 | 0: 4-clock load interval; 1: 8-clock load interval for cascading |
| par_i | input | WORD_W | Parallel word, bit 0 sent first |
| ser_i | input | 1 | Cascade serial input, enters behind the top bit |
| ser_o | output | 1 | Serial data, updated on the falling clock edge |
| div_word_o | output | 1 | Clock divided by 4 |
| div_pair_o | output | 1 | Clock divided by 8 |

## Verification
The bench restarts frames at several counter phases and checks that the first load lands exactly on the third rising edge after sync. A design that loaded one edge early or late would shift every serial bit by one position and fail the bit-order checks.

Parallel data is replaced with random values between loads. A design that sampled `par_i` outside the load edge would then corrupt the stream. Every bit is sampled both just after the rising edge and just after the falling edge, which catches an output register clocked on the wrong edge.

Two units are chained in eight-clock mode, and a second run uses a random serial input. A design that lost or duplicated a bit at the cascade join, or kept loading every four clocks, would show wrong upper-half bits. Sync is raised while the eighth-rate clock is high, and both divided clocks are checked before any clock edge. This exposes a divider whose clear is only synchronous.

// File: rtl/ps_pkg.sv
// Shared types for the parallel-to-serial converter.
package ps_pkg;
    // Load interval selection: one word per frame, or a cascaded pair.
    typedef enum logic {
        SPAN_SINGLE  = 1'b0,
        SPAN_CASCADE = 1'b1
    } span_e;
endpackage

// File: rtl/ps_sync_release.sv
// Stretches the asynchronous sync request and retimes its release.
// Assertion of sync_i is seen at once. Release waits STAGES rising edges.
// Assumes STAGES >= 2.
module ps_sync_release #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic hold_o,
    output logic quiet_o
);
    logic [STAGES-1:0] stg;

    // Async set by sync_i; ones drain out one stage per edge after release.
    always_ff @(posedge clk or posedge sync_i) begin
        if (sync_i) begin
            stg <= '1;
        end else if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], 1'b0};
        end
    end

    assign hold_o  = stg[STAGES-1];
    assign quiet_o = |stg;
endmodule

// File: rtl/ps_load_gen.sv
// Phase counter that produces the load pulse and the two divided clocks.
// Assumes WORD_W is a power of two, at least 2.
// The counter clears asynchronously while hold_i is high.
module ps_load_gen #(
    parameter int WORD_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic          quiet_i,
    input  ps_pkg::span_e span_i,
    output logic          load_o,
    output logic          div_word_o,
    output logic          div_pair_o
);
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] STEP = 1;

    logic [CNT_W-1:0] phase;
    logic             word_wrap;
    logic             pair_wrap;

    // Free-running phase, cleared by hold at once or by reset at an edge.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i) begin
            phase <= '0;
        end else if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + STEP;
        end
    end

    // Load at phase zero of the selected interval, never during a hold.
    always_comb begin
        word_wrap = (phase[CNT_W-2:0] == '0);
        pair_wrap = (phase == '0);
        if (span_i == ps_pkg::SPAN_CASCADE) begin
            load_o = !quiet_i && pair_wrap;
        end else begin
            load_o = !quiet_i && word_wrap;
        end
    end

    assign div_word_o = phase[CNT_W-2];
    assign div_pair_o = phase[CNT_W-1];
endmodule

// File: rtl/ps_shift_chain.sv
// Loadable shift chain. On a load, each stage takes its own parallel bit.
// Otherwise it takes its upper neighbour; the top stage takes ser_i.
// Stage 0 is retimed onto the falling clock edge to drive ser_o.
module ps_shift_chain #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] par_i,
    input  logic              ser_i,
    output logic              head_o,
    output logic              ser_o
);
    logic [WORD_W-1:0] stage;
    logic [WORD_W-1:0] nxt;

    generate
        for (genvar k = 0; k < WORD_W; k++) begin : g_stage
            if (k == WORD_W - 1) begin : g_top
                assign nxt[k] = load_i ? par_i[k] : ser_i;
            end else begin : g_mid
                assign nxt[k] = load_i ? par_i[k] : stage[k+1];
            end
        end
    endgenerate

    // Rising-edge load or shift of the whole chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage <= nxt;
        end
    end

    // Falling-edge output register, so the line is stable at rising edges.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ser_o <= 1'b0;
        end else begin
            ser_o <= stage[0];
        end
    end

    assign head_o = stage[0];
endmodule

// File: rtl/par_serializer.sv
// Cascadable parallel-to-serial converter with divide-by-4 and divide-by-8
// clock outputs. Inputs are single-ended and synchronous to clk, except
// sync_i, which may arrive at any time.
module par_serializer #(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              mode8_i,
    input  logic [WORD_W-1:0] par_i,
    input  logic              ser_i,
    output logic              ser_o,
    output logic              div_word_o,
    output logic              div_pair_o
);
    logic          hold;
    logic          quiet;
    logic          load;
    logic          head;
    ps_pkg::span_e span;

    assign span = mode8_i ? ps_pkg::SPAN_CASCADE : ps_pkg::SPAN_SINGLE;

    ps_sync_release #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_i),
        .hold_o  (hold),
        .quiet_o (quiet)
    );

    ps_load_gen #(.WORD_W(WORD_W)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .quiet_i    (quiet),
        .span_i     (span),
        .load_o     (load),
        .div_word_o (div_word_o),
        .div_pair_o (div_pair_o)
    );

    ps_shift_chain #(.WORD_W(WORD_W)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .par_i  (par_i),
        .ser_i  (ser_i),
        .head_o (head),
        .ser_o  (ser_o)
    );
endmodule

// File: rtl/ps_checker.sv
// Temporal checks for par_serializer, attached by bind.
module ps_checker (
    input logic clk,
    input logic rst_n,
    input logic mode8_i,
    input logic hold_i,
    input logic load_i,
    input logic head_i,
    input logic ser_o,
    input logic div_word_i,
    input logic div_pair_i
);
    // R2: the quarter-rate clock holds each level for two cycles
    assert_div_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        !$stable(div_word_i) |=> $stable(div_word_i));

    // R2: the eighth-rate clock rises only as the quarter-rate clock falls
    assert_pair_edge_R2: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        $rose(div_pair_i) |-> $fell(div_word_i));

    // R3: loads are at least four cycles apart
    assert_load_gap_R3: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        load_i |=> !load_i ##1 !load_i ##1 !load_i);

    // R4: in cascade mode a load falls where both divided clocks are low
    assert_pair_load_phase_R4: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        (mode8_i && load_i) |-> (!div_word_i && !div_pair_i));

    // R6: at each rising edge the line shows the bit the chain held before it
    assert_out_follows_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_o == head_i);

    // R7: while held, both divided clocks stay low
    assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> (!div_word_i && !div_pair_i));
endmodule

bind par_serializer ps_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode8_i    (mode8_i),
    .hold_i     (hold),
    .load_i     (load),
    .head_i     (head),
    .ser_o      (ser_o),
    .div_word_i (div_word_o),
    .div_pair_i (div_pair_o)
);

// File: tb/tb_par_serializer.sv
`timescale 1ns/100ps
module tb_par_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic       mode8 = 1'b0;
    logic [3:0] par = 4'h0;
    logic [3:0] up_par = 4'h0;
    logic       tb_ser = 1'b0;
    logic       casc = 1'b0;
    logic       ser_o, div_word, div_pair;
    logic       up_ser, up_dw, up_dp;
    logic       dut_ser_in;
    logic [3:0] words [4];
    logic [3:0] upw [4];
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    assign dut_ser_in = casc ? up_ser : tb_ser;

    always #2 clk = ~clk;

    par_serializer dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode8_i(mode8),
        .par_i(par), .ser_i(dut_ser_in), .ser_o(ser_o),
        .div_word_o(div_word), .div_pair_o(div_pair)
    );

    par_serializer dut_up (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .mode8_i(mode8),
        .par_i(up_par), .ser_i(tb_ser), .ser_o(up_ser),
        .div_word_o(up_dw), .div_pair_o(up_dp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // R10: reset clears the serial line and both divided clocks.
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        chk("R10 ser_o", ser_o, 0);
        chk("R10 div_word", div_word, 0);
        chk("R10 div_pair", div_pair, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // R8: pulse sync; returns just after the second rising edge after release.
    task automatic start_frame();
        @(posedge clk); #1 sync_i = 1'b1;
        @(posedge clk); #1 sync_i = 1'b0;
        @(posedge clk); #3;
        chk("R8 div_word low", div_word, 0);
        chk("R8 div_pair low", div_pair, 0);
        @(posedge clk); #1;
    endtask

    // R1 R3 R4 R5 R6 R8 R9 R2: run whole frames and check every bit time.
    task automatic run_frames(input logic m8, input logic c, input int nframes);
        logic expv [64];
        logic serd [64];
        int   len;
        int   nbits;
        int   k;
        int   f;
        string req;
        len = m8 ? 8 : 4;
        nbits = nframes * len;
        mode8 = m8;
        casc = c;
        req = m8 ? (c ? "R5 cascade" : "R4 R5 serial-in") : "R1 R3 R9";
        start_frame();
        par = words[0];
        up_par = upw[0];
        tb_ser = 1'($urandom);
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk);
            #1;
            if (i > 0) chk("R6 held until falling edge", ser_o, expv[i-1]);
            if (((i + 1) % len == 0) && ((i + 1) / len < nframes)) begin
                par = words[(i + 1) / len];
                up_par = upw[(i + 1) / len];
            end else begin
                par = 4'($urandom);
                up_par = 4'($urandom);
            end
            tb_ser = 1'($urandom);
            serd[i] = tb_ser;
            k = i % len;
            f = i / len;
            if (k < 4) expv[i] = words[f][k];
            else if (c) expv[i] = upw[f][k-4];
            else expv[i] = serd[i-4];
            #2;
            chk(i == 0 ? "R8 first load edge" : req, ser_o, expv[i]);
            chk("R2 div_word", div_word, ((i + 1) >> 1) & 1);
            chk("R2 div_pair", div_pair, ((i + 1) >> 2) & 1);
        end
    endtask

    // R7: sync clears the divided clocks without any clock edge.
    task automatic test_sync_async();
        mode8 = 1'b1;
        casc = 1'b0;
        for (int n = 0; n < 16; n++) begin
            @(posedge clk); #1;
            if (div_pair) break;
        end
        chk("R7 precondition div_pair high", div_pair, 1);
        sync_i = 1'b1;
        #0.5;
        chk("R7 async div_word", div_word, 0);
        chk("R7 async div_pair", div_pair, 0);
        for (int n = 0; n < 3; n++) begin
            @(posedge clk); #3;
            chk("R7 held div_word", div_word, 0);
            chk("R7 held div_pair", div_pair, 0);
        end
        @(posedge clk); #1 sync_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        words[0] = 4'hA; words[1] = 4'h3; words[2] = 4'h8; words[3] = 4'h1;
        upw[0] = 4'h0; upw[1] = 4'h0; upw[2] = 4'h0; upw[3] = 4'h0;
        run_frames(1'b0, 1'b0, 3);
        repeat (3) @(posedge clk);
        words[0] = 4'h6; words[1] = 4'hF; words[2] = 4'h0; words[3] = 4'h9;
        run_frames(1'b0, 1'b0, 4);
        test_sync_async();
        words[0] = 4'hC; words[1] = 4'h5;
        run_frames(1'b1, 1'b0, 2);
        words[0] = 4'h2; words[1] = 4'hD;
        upw[0] = 4'hB; upw[1] = 4'h4;
        run_frames(1'b1, 1'b1, 2);
        words[0] = 4'h7;
        run_frames(1'b0, 1'b0, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule